// File: doc/BRIEF.md
# Cascadable Segment Column Data Loader

This block gathers pixel data for one line of a 160-column segment driver. Data comes in on an 8-bit bus. A data strobe marks each transfer. The block runs in one of two modes:

- **Nibble mode:** each strobe carries 4 bits, and two strobes make one byte.
- **Byte mode:** each strobe carries a full byte.

Every two bytes form a 16-bit group. The group is written into a 160-bit staging latch at a slot chosen by a group pointer. The pointer moves by one slot per group. A direction input sets the fill order: from the low columns upward, or from the high columns downward.

Several of these blocks are chained to drive a wide panel, one enable passing down the chain:

- The line pulse clears all loading state. The block then waits for its upstream enable.
- Once enabled, it takes exactly 20 bytes.
- It then raises its downstream enable and ignores all further strobes until the next line pulse.
- The direction input also swaps which enable pin acts as the chain input and which acts as the chain output.

When the line pulse falls, the whole staging latch is copied at once into the line output register.

Top module: `seg_column_loader`

## Requirements
- R1: While reset is asserted and right after it, `line_out` is all zeros and both chain outputs are low.
- R2: When `wide_mode`=1, every accepted strobe takes one byte from `din[7:0]`. The first byte of each group fills bits [7:0] of the group and the second fills bits [15:8].
- R3: When `wide_mode`=0, each byte takes two accepted strobes using only `din[3:0]`. The first nibble becomes bits [3:0] of the byte, the second becomes bits [7:4], and `din[7:4]` is ignored.
- R4: When `dir_rev`=0, group k (k=0..9) is written to `line` bits [16k+15:16k]. The chain input is `chain_in_a`, the chain output is `chain_out_b`, and `chain_in_b` has no effect.
- R5: When `dir_rev`=1, group k is written to `line` bits [16(9-k)+15:16(9-k)]. The chain input is `chain_in_b`, the chain output is `chain_out_a`, and `chain_in_a` has no effect.
- R6: A strobe is ignored unless the active chain input is high in that cycle or has been high since the last line pulse.
- R7: The active chain output rises one cycle after the strobe that completes the 20th byte. It stays high until `lp` is sampled high. While it is high, strobes change nothing.
- R8: `lp` high clears the group pointer, the byte and nibble phases and the selection, and drops the chain output in the next cycle. A partly loaded group is discarded, and a new load starts at group 0.
- R9: At the first clock edge where `lp` is low after being high, `line_out` takes all 160 staging bits together.
- R10: `line_out` changes at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Line pulse; high clears loading, falling edge transfers the line |
| dstb | input | 1 | Data strobe, one transfer per high cycle |
| wide_mode | input | 1 | 1 = byte per strobe, 0 = nibble per strobe |
| dir_rev | input | 1 | Fill direction and chain pin swap |
| din | input | 8 | Pixel data bus |
| chain_in_a | input | 1 | Chain enable input when dir_rev=0 |
| chain_in_b | input | 1 | Chain enable input when dir_rev=1 |
| chain_out_a | output | 1 | Chain enable output when dir_rev=1 |
| chain_out_b | output | 1 | Chain enable output when dir_rev=0 |
| line_out | output | 160 | Line output register |

## Verification
The assertions assume the mode and direction inputs change only while `lp` is high, so a line never mixes packing modes or fill orders. The stimulus changes both only inside the line pulse. It also drives data, strobes, idle gaps and the unused upper nibble at random from a fixed seed. Directed lines cover the remaining cases:
- strobes before selection, with the wrong-side chain pin high;
- strobes after the line is full;
- a partial load cut off by a line pulse.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int unsigned DEF_COLS  = 160;
  localparam int unsigned DEF_BUS_W = 8;
  localparam int unsigned DEF_GRP_W = 16;

  typedef enum logic {
    FILL_UP   = 1'b0,
    FILL_DOWN = 1'b1
  } fill_dir_e;

  typedef struct packed {
    logic sel;
    logic done;
  } chain_state_t;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seg_byte_pack.sv
module seg_byte_pack #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic             wide,
  input  logic [BUS_W-1:0] din,
  output logic             byte_vld,
  output logic [BUS_W-1:0] byte_dat
);
  localparam int unsigned HALF_W = BUS_W / 2;

  logic              ph_q, ph_d;
  logic [HALF_W-1:0] nib_q, nib_d;

  always_comb begin
    ph_d  = ph_q;
    nib_d = nib_q;
    if (clr) begin
      ph_d = 1'b0;
    end else if (stb && !wide) begin
      ph_d = !ph_q;
      if (!ph_q) nib_d = din[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      nib_q <= '0;
    end else begin
      ph_q  <= ph_d;
      nib_q <= nib_d;
    end
  end

  assign byte_vld = stb && !clr && (wide || ph_q);
  assign byte_dat = wide ? din : {din[HALF_W-1:0], nib_q};
endmodule

// File: rtl/seg_group_ptr.sv
module seg_group_ptr #(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned GRP_W = 16,
  parameter int unsigned NGRP  = 10,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dir_rev,
  input  logic             byte_vld,
  input  logic [BUS_W-1:0] byte_dat,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_slot,
  output logic [GRP_W-1:0] wr_data,
  output logic             grp_last,
  output logic [CNT_W-1:0] grp_cnt
);
  localparam int unsigned BPG = GRP_W / BUS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NGRP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (BPG == 1) begin : g_direct
      assign wr_en   = byte_vld;
      assign wr_data = byte_dat;
    end else begin : g_gather
      localparam int unsigned BI_W  = $clog2(BPG);
      localparam int unsigned HLD_W = GRP_W - BUS_W;
      localparam logic [BI_W-1:0] BI_MAX = BI_W'(BPG - 1);

      logic [BI_W-1:0]  bidx_q, bidx_d;
      logic [HLD_W-1:0] hold_q, hold_d;

      always_comb begin
        bidx_d = bidx_q;
        hold_d = hold_q;
        if (clr) begin
          bidx_d = '0;
        end else if (byte_vld) begin
          if (bidx_q == BI_MAX) begin
            bidx_d = '0;
          end else begin
            bidx_d = bidx_q + 1'b1;
            hold_d[int'(bidx_q)*BUS_W +: BUS_W] = byte_dat;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bidx_q <= '0;
          hold_q <= '0;
        end else begin
          bidx_q <= bidx_d;
          hold_q <= hold_d;
        end
      end

      assign wr_en   = byte_vld && (bidx_q == BI_MAX);
      assign wr_data = {byte_dat, hold_q};
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign grp_last = wr_en && (cnt_q == CNT_MAX);
  assign wr_slot  = dir_rev ? (CNT_MAX - cnt_q) : cnt_q;
  assign grp_cnt  = cnt_q;
endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int unsigned COLS  = 160,
  parameter int unsigned GRP_W = 16,
  parameter int unsigned NGRP  = 10,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_slot,
  input  logic [GRP_W-1:0] wr_data,
  input  logic             xfer,
  output logic [COLS-1:0]  latch_bits,
  output logic [COLS-1:0]  line_bits
);
  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_slot
      logic             hit;
      logic [GRP_W-1:0] slot_q;

      assign hit = wr_en && (wr_slot == CNT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot_q <= '0;
        else if (hit) slot_q <= wr_data;
      end

      assign latch_bits[g*GRP_W +: GRP_W] = slot_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_bits <= '0;
    else if (xfer) line_bits <= latch_bits;
  end
endmodule

// File: rtl/seg_column_loader.sv
module seg_column_loader
  import seg_loader_pkg::*;
#(
  parameter int unsigned COLS  = DEF_COLS,
  parameter int unsigned BUS_W = DEF_BUS_W,
  parameter int unsigned GRP_W = DEF_GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp,
  input  logic             dstb,
  input  logic             wide_mode,
  input  logic             dir_rev,
  input  logic [BUS_W-1:0] din,
  input  logic             chain_in_a,
  input  logic             chain_in_b,
  output logic             chain_out_a,
  output logic             chain_out_b,
  output logic [COLS-1:0]  line_out
);
  localparam int unsigned NGRP  = COLS / GRP_W;
  localparam int unsigned CNT_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic             rst_i_n;
  logic             lp_d;
  chain_state_t     cs_q, cs_d;
  logic             cin, act, stb_acc;
  logic             byte_vld;
  logic [BUS_W-1:0] byte_dat;
  logic             wr_en, grp_last;
  logic [CNT_W-1:0] wr_slot, grp_cnt;
  logic [GRP_W-1:0] wr_data;
  logic [COLS-1:0]  latch_bits;
  logic             xfer;
  fill_dir_e        fdir;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign fdir    = fill_dir_e'(dir_rev);
  assign cin     = (fdir == FILL_DOWN) ? chain_in_b : chain_in_a;
  assign act     = !lp && !cs_q.done && (cs_q.sel || cin);
  assign stb_acc = dstb && act;
  assign xfer    = lp_d && !lp;

  seg_byte_pack #(.BUS_W(BUS_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (lp),
    .stb      (stb_acc),
    .wide     (wide_mode),
    .din      (din),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat)
  );

  seg_group_ptr #(
    .BUS_W (BUS_W),
    .GRP_W (GRP_W),
    .NGRP  (NGRP),
    .CNT_W (CNT_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (lp),
    .dir_rev  (dir_rev),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_data  (wr_data),
    .grp_last (grp_last),
    .grp_cnt  (grp_cnt)
  );

  seg_line_store #(
    .COLS  (COLS),
    .GRP_W (GRP_W),
    .NGRP  (NGRP),
    .CNT_W (CNT_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_data    (wr_data),
    .xfer       (xfer),
    .latch_bits (latch_bits),
    .line_bits  (line_out)
  );

  always_comb begin
    cs_d = cs_q;
    if (lp) begin
      cs_d.sel  = 1'b0;
      cs_d.done = 1'b0;
    end else begin
      cs_d.sel  = !cs_q.done && !grp_last && (cs_q.sel || cin);
      cs_d.done = cs_q.done || grp_last;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cs_q <= '0;
      lp_d <= 1'b0;
    end else begin
      cs_q <= cs_d;
      lp_d <= lp;
    end
  end

  assign chain_out_a = cs_q.done && (fdir == FILL_DOWN);
  assign chain_out_b = cs_q.done && (fdir == FILL_UP);
endmodule

// File: rtl/seg_column_loader_chk.sv
module seg_column_loader_chk #(
  parameter int unsigned COLS  = 160,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lp,
  input logic             chain_out_a,
  input logic             chain_out_b,
  input logic [COLS-1:0]  line_out,
  input logic [COLS-1:0]  latch_bits,
  input logic [CNT_W-1:0] grp_cnt
);
  logic out_any;
  assign out_any = chain_out_a || chain_out_b;

  assert_single_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chain_out_a, chain_out_b}));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_any && !lp) |=> out_any);

  assert_latch_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_any && !lp) |=> $stable(latch_bits));

  assert_out_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !out_any);

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> (grp_cnt == '0));

  assert_line_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lp) |=> $stable(line_out));
endmodule

bind seg_column_loader seg_column_loader_chk #(
  .COLS  (COLS),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lp          (lp),
  .chain_out_a (chain_out_a),
  .chain_out_b (chain_out_b),
  .line_out    (line_out),
  .latch_bits  (latch_bits),
  .grp_cnt     (grp_cnt)
);

// File: tb/seg_column_loader_tb.sv
module seg_column_loader_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         lp, dstb, wide_mode, dir_rev, cin_a, cin_b;
  logic [7:0]   din;
  logic         cout_a, cout_b;
  logic [159:0] line_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [159:0] m_latch = '0, m_line = '0;
  logic         m_sel = 0, m_done = 0, m_nph = 0, m_bph = 0, m_lpd = 0;
  logic [3:0]   m_nib = '0;
  logic [7:0]   m_hold = '0;
  int           m_grp = 0;

  logic [7:0]   cur_b [20];
  logic [159:0] last_exp = '0;
  bit           last_full = 0;
  bit           last_wide = 0, last_rev = 0;

  always #5 clk = ~clk;

  seg_column_loader u_dut (
    .clk(clk), .rst_n(rst_n), .lp(lp), .dstb(dstb), .wide_mode(wide_mode),
    .dir_rev(dir_rev), .din(din), .chain_in_a(cin_a), .chain_in_b(cin_b),
    .chain_out_a(cout_a), .chain_out_b(cout_b), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [159:0] got,
                     input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [159:0] expect_line(input bit rev);
    logic [159:0] v = '0;
    for (int k = 0; k < 10; k++) begin
      int slot = rev ? 9 - k : k;
      v[slot*16 +: 16] = {cur_b[2*k+1], cur_b[2*k]};
    end
    return v;
  endfunction

  task automatic model_edge();
    logic c, act, gotb;
    logic [7:0] b;
    int slot;
    c = dir_rev ? cin_b : cin_a;
    b = '0;
    if (!lp && m_lpd) m_line = m_latch;
    if (lp) begin
      m_sel = 0; m_done = 0; m_grp = 0; m_nph = 0; m_bph = 0;
    end else begin
      act  = !m_done && (m_sel || c);
      gotb = 0;
      if (act && dstb) begin
        if (wide_mode) begin b = din; gotb = 1; end
        else if (!m_nph) begin m_nib = din[3:0]; m_nph = 1; end
        else begin b = {din[3:0], m_nib}; m_nph = 0; gotb = 1; end
      end
      if (act) m_sel = 1;
      if (gotb) begin
        if (!m_bph) begin
          m_hold = b; m_bph = 1;
        end else begin
          slot = dir_rev ? 9 - m_grp : m_grp;
          m_latch[slot*16 +: 16] = {b, m_hold};
          m_bph = 0;
          m_grp++;
          if (m_grp == 10) begin m_done = 1; m_sel = 0; m_grp = 0; end
        end
      end
    end
    m_lpd = lp;
  endtask

  task automatic step(input logic s, input logic [7:0] d);
    dstb = s;
    din  = d;
    model_edge();
    @(negedge clk);
    chk(line_out == m_line, "R10", line_out, m_line);
    chk(cout_a == (m_done && dir_rev) && cout_b == (m_done && !dir_rev), "R7",
        {cout_a, cout_b}, {m_done && dir_rev, m_done && !dir_rev});
  endtask

  task automatic put_byte(input logic [7:0] b);
    int gap = $urandom_range(0, 2);
    for (int g = 0; g < gap; g++) step(1'b0, 8'($urandom));
    if (wide_mode) begin
      step(1'b1, b);
    end else begin
      step(1'b1, {4'($urandom), b[3:0]});
      step(1'b1, {4'($urandom), b[7:4]});
    end
  endtask

  task automatic run_line(input bit w, input bit r, input int nbytes, input bit pre);
    lp = 1; wide_mode = w; dir_rev = r; cin_a = 0; cin_b = 0;
    step(1'b1, 8'($urandom));
    step(1'b0, 8'h00);
    chk(!cout_a && !cout_b, "R8", {cout_a, cout_b}, 160'd0);
    lp = 0;
    step(1'b0, 8'h00);
    chk(line_out == m_line, "R9", line_out, m_line);
    if (last_full)
      chk(line_out == last_exp,
          $sformatf("R9 %s %s", last_wide ? "R2" : "R3", last_rev ? "R5" : "R4"),
          line_out, last_exp);
    if (pre) begin
      if (r) cin_a = 1; else cin_b = 1;
      for (int i = 0; i < 3; i++) put_byte(8'($urandom));
      chk(!cout_a && !cout_b, "R6", {cout_a, cout_b}, 160'd0);
      cin_a = 0; cin_b = 0;
    end
    if (r) cin_b = 1; else cin_a = 1;
    for (int i = 0; i < 20; i++) cur_b[i] = 8'($urandom);
    for (int i = 0; i < nbytes; i++) put_byte(cur_b[i]);
    if (nbytes == 20) begin
      chk(r ? (cout_a && !cout_b) : (cout_b && !cout_a), r ? "R5" : "R4",
          {cout_a, cout_b}, {r, !r});
      for (int i = 0; i < 2; i++) put_byte(8'($urandom));
      chk(cout_a || cout_b, "R7", {cout_a, cout_b}, 160'd1);
      last_exp = expect_line(r);
      last_full = 1; last_wide = w; last_rev = r;
    end else begin
      last_full = 0;
      chk(!cout_a && !cout_b, "R8", {cout_a, cout_b}, 160'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; lp = 0; dstb = 0; wide_mode = 1; dir_rev = 0;
    cin_a = 0; cin_b = 0; din = '0;
    repeat (3) @(negedge clk);
    chk(line_out == '0 && !cout_a && !cout_b, "R1", line_out, 160'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(line_out == '0 && !cout_a && !cout_b, "R1", line_out, 160'd0);

    run_line(1, 0, 20, 0);
    run_line(0, 1, 20, 1);
    run_line(1, 0, 7, 0);
    run_line(0, 0, 13, 1);
    run_line(0, 0, 20, 0);
    run_line(1, 1, 20, 1);
    for (int n = 0; n < 12; n++)
      run_line(1'($urandom), 1'($urandom),
               ($urandom_range(0, 3) == 0) ? $urandom_range(0, 19) : 20,
               1'($urandom));
    run_line(1, 1, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule